// File: doc/BRIEF.md
# Map Call-Record Reuse Cache

This block sits beside one processing unit's dispatch port. Every queue entry that reaches the unit carries a call-record address, a flag saying whether the call came from mapping a function over a list, and the list element for that call. Calls produced by one map all share a single call record, so copying that record across the interconnect for each element wastes bandwidth. The block keeps one remembered call-record address. When a map-flagged entry names that address while the entry is still live, the block reports a hit and the unit starts at once without a remote copy. In every other case it issues a fetch request and waits for the transfer to finish.

An entry stays live only for a limited time. A countdown is loaded from a runtime-programmable decay constant when a record is captured and again on every reuse. When the countdown is spent the entry dies. Calls without the map flag always fetch and never disturb the remembered entry. When a map call starts, whether on a hit or when its fetch finishes, the block flags that the record's varying argument must be replaced by the list element and presents that element.

Top module: `map_record_cache`

## Requirements
- R1: A dispatch with `disp_is_map_i`=0 raises `fetch_req_o` in the same cycle, never raises `hit_o`, and leaves the remembered address and its remaining lifetime unchanged.
- R2: A map dispatch hits (`hit_o`=1, `fetch_req_o`=0, `start_o`=1 in that cycle) only when its address equals the remembered address and the entry is live.
- R3: A map dispatch that misses raises `fetch_req_o` with `fetch_addr_o` equal to the dispatched address; when that fetch completes, the address becomes the remembered address and the entry becomes live.
- R4: With decay constant D loaded in cycle c, a lookup of the remembered address hits in cycles c+1 to c+D and misses from c+D+1 on; D=0 gives an entry that never hits.
- R5: Each hit reloads the lifetime, so the window of R4 restarts from the hit cycle.
- R6: The decay constant is sampled only in the cycle the lifetime is loaded; changing `decay_cfg_i` afterwards does not alter the running lifetime.
- R7: A lookup in the cycle in which the lifetime runs out (c+D+1) is a miss and starts a fetch.
- R8: After reset nothing is live: `busy_o`, `fetch_req_o` and `hit_o` are 0, and the first map lookup misses, for any address.
- R9: A map call starts with `start_arg_sub_o`=1 and `start_arg_o` equal to its list element: in the dispatch cycle on a hit, in the `fetch_done_i` cycle on a miss. A non-map call starts with `start_arg_sub_o`=0.
- R10: After a fetch request `busy_o` is 1 from the next cycle until the cycle in which `fetch_done_i` is seen, inclusive; `start_o` is 1 in that completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| decay_cfg_i | input | CNT_W | Decay constant, sampled when a lifetime is loaded |
| disp_valid_i | input | 1 | Queue entry presented for dispatch (only while `busy_o`=0) |
| disp_is_map_i | input | 1 | Entry was generated by mapping over a list |
| disp_cr_addr_i | input | ADDR_W | Call-record address of the entry |
| disp_map_param_i | input | DATA_W | List element for a map entry |
| fetch_done_i | input | 1 | Remote record transfer finished |
| hit_o | output | 1 | Remembered record reused, remote copy skipped |
| fetch_req_o | output | 1 | Request a remote copy of the record |
| fetch_addr_o | output | ADDR_W | Address of the record to copy |
| busy_o | output | 1 | A fetch is outstanding |
| start_o | output | 1 | The call may begin execution this cycle |
| start_arg_sub_o | output | 1 | Replace the varying argument with `start_arg_o` |
| start_arg_o | output | DATA_W | List element for the starting call |

## Verification
The case that matters is a lookup landing in the very cycle the lifetime runs out, where a hit decision and the expiry compete. The bench provokes it by sweeping, for several decay constants, the gap between a capture (or a reuse) and the next lookup through D, D+1 and beyond, with the fetch latency also varied. The expected hit or miss is computed from the gap and the sampled constant alone, and a lookup at gap D+1 must miss and raise a fetch.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_MAP   = 2'd1,
    FILL_PLAIN = 2'd2
  } fill_kind_e;
endpackage

// File: rtl/mrc_decay_timer.sv
module mrc_decay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             live_o,
  output logic             expiring_o
);
  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      cnt_q   <= load_val_i;
    end else if (valid_q) begin
      if (cnt_q == '0) valid_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  // expiry cycle: still flagged valid but counter spent
  assign expiring_o = valid_q && (cnt_q == '0);
  assign live_o     = valid_q && (cnt_q != '0);
endmodule

// File: rtl/mrc_tag_store.sv
module mrc_tag_store #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] capture_addr_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tag_q <= '0;
    else if (capture_i) tag_q <= capture_addr_i;
  end

  assign match_o = (tag_q == probe_addr_i);
endmodule

// File: rtl/mrc_fetch_ctrl.sv
module mrc_fetch_ctrl
  import mrc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              launch_map_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  logic [DATA_W-1:0] launch_param_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              fill_map_o,
  output logic              fill_any_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [DATA_W-1:0] fill_param_o
);
  fill_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] param_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= FILL_NONE;
      addr_q  <= '0;
      param_q <= '0;
    end else if (launch_i) begin
      kind_q  <= launch_map_i ? FILL_MAP : FILL_PLAIN;
      addr_q  <= launch_addr_i;
      param_q <= launch_param_i;
    end else if (done_i && kind_q != FILL_NONE) begin
      kind_q  <= FILL_NONE;
    end
  end

  assign busy_o       = (kind_q != FILL_NONE);
  assign fill_any_o   = busy_o && done_i;
  assign fill_map_o   = fill_any_o && (kind_q == FILL_MAP);
  assign fill_addr_o  = addr_q;
  assign fill_param_o = param_q;
endmodule

// File: rtl/map_record_cache.sv
module map_record_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  decay_cfg_i,
  input  logic              disp_valid_i,
  input  logic              disp_is_map_i,
  input  logic [ADDR_W-1:0] disp_cr_addr_i,
  input  logic [DATA_W-1:0] disp_map_param_i,
  input  logic              fetch_done_i,
  output logic              hit_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              busy_o,
  output logic              start_o,
  output logic              start_arg_sub_o,
  output logic [DATA_W-1:0] start_arg_o
);
  logic              accept, lookup, tag_match, live, expiring;
  logic              fill_map, fill_any, load;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_param;

  assign accept = disp_valid_i && !busy_o;
  assign lookup = accept && disp_is_map_i;
  // expiring entry counts as dead: lookup in that cycle misses
  assign hit_o       = lookup && tag_match && live && !expiring;
  assign fetch_req_o = accept && !hit_o;
  assign fetch_addr_o = disp_cr_addr_i;
  assign load = hit_o || fill_map;

  mrc_decay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (decay_cfg_i),
    .live_o     (live),
    .expiring_o (expiring)
  );

  mrc_tag_store #(.ADDR_W(ADDR_W)) u_tag (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .capture_i      (fill_map),
    .capture_addr_i (fill_addr),
    .probe_addr_i   (disp_cr_addr_i),
    .match_o        (tag_match)
  );

  mrc_fetch_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .launch_i       (fetch_req_o),
    .launch_map_i   (disp_is_map_i),
    .launch_addr_i  (disp_cr_addr_i),
    .launch_param_i (disp_map_param_i),
    .done_i         (fetch_done_i),
    .busy_o         (busy_o),
    .fill_map_o     (fill_map),
    .fill_any_o     (fill_any),
    .fill_addr_o    (fill_addr),
    .fill_param_o   (fill_param)
  );

  assign start_o         = hit_o || fill_any;
  assign start_arg_sub_o = hit_o || fill_map;
  assign start_arg_o     = hit_o ? disp_map_param_i : fill_param;
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  decay_cfg_i,
  input logic              disp_valid_i,
  input logic              disp_is_map_i,
  input logic [ADDR_W-1:0] disp_cr_addr_i,
  input logic [DATA_W-1:0] disp_map_param_i,
  input logic              fetch_done_i,
  input logic              hit_o,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              busy_o,
  input logic              start_o,
  input logic              start_arg_sub_o,
  input logic [DATA_W-1:0] start_arg_o
);
  logic             armed_q, pend_map_q;
  logic [CNT_W:0]   age_q;
  logic [CNT_W-1:0] cfg_q;
  logic             map_fill;

  assign map_fill = busy_o && fetch_done_i && pend_map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0; pend_map_q <= 1'b0; age_q <= '0; cfg_q <= '0;
    end else begin
      if (fetch_req_o) pend_map_q <= disp_is_map_i;
      if (hit_o || map_fill) begin
        armed_q <= 1'b1; age_q <= 1; cfg_q <= decay_cfg_i;
      end else if (age_q != '1) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  a_r2_hit_needs_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> disp_valid_i && disp_is_map_i && !fetch_req_o && start_o);
  a_r1_plain_fetches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && !disp_is_map_i && !busy_o) |-> fetch_req_o && !hit_o);
  a_r3_fetch_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> fetch_addr_o == disp_cr_addr_i);
  a_r10_busy_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> busy_o);
  a_r9_hit_arg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> start_arg_sub_o && start_arg_o == disp_map_param_i);
  // R4, R5, R7, R8: hit only inside the window opened by the last load
  a_r4_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> armed_q && (age_q <= {1'b0, cfg_q}));
endmodule

bind map_record_cache mrc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .decay_cfg_i(decay_cfg_i),
  .disp_valid_i(disp_valid_i), .disp_is_map_i(disp_is_map_i),
  .disp_cr_addr_i(disp_cr_addr_i), .disp_map_param_i(disp_map_param_i),
  .fetch_done_i(fetch_done_i), .hit_o(hit_o), .fetch_req_o(fetch_req_o),
  .fetch_addr_o(fetch_addr_o), .busy_o(busy_o), .start_o(start_o),
  .start_arg_sub_o(start_arg_sub_o), .start_arg_o(start_arg_o)
);

// File: tb/tb_map_record_cache.sv
module tb_map_record_cache;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [CNT_W-1:0]  decay_cfg_i = '0;
  logic              disp_valid_i = 1'b0;
  logic              disp_is_map_i = 1'b0;
  logic [ADDR_W-1:0] disp_cr_addr_i = '0;
  logic [DATA_W-1:0] disp_map_param_i = '0;
  logic              fetch_done_i = 1'b0;
  logic              hit_o, fetch_req_o, busy_o, start_o, start_arg_sub_o;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic [DATA_W-1:0] start_arg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk_i = ~clk_i;

  map_record_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one dispatch cycle; checks the same-cycle decision
  task automatic dispatch(input bit is_map, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] prm, input bit exp_hit, input string req);
    @(negedge clk_i);
    disp_valid_i = 1'b1; disp_is_map_i = is_map;
    disp_cr_addr_i = addr; disp_map_param_i = prm;
    #1;
    chk(hit_o, exp_hit, req);
    chk(fetch_req_o, !exp_hit, req);
    if (!exp_hit) chk(fetch_addr_o, addr, {req, " R3 addr"});
    if (exp_hit) begin
      chk(start_o, 1, {req, " R2 start"});
      chk({start_arg_sub_o, start_arg_o}, {1'b1, prm}, {req, " R9 hit arg"});
    end
    @(posedge clk_i); #1;
    disp_valid_i = 1'b0;
  endtask

  // completes an outstanding fetch after lat extra cycles
  task automatic finish_fetch(input int lat, input bit is_map, input logic [DATA_W-1:0] prm);
    chk(busy_o, 1, "R10 busy after request");
    repeat (lat) @(posedge clk_i);
    @(negedge clk_i);
    fetch_done_i = 1'b1;
    #1;
    chk(busy_o, 1, "R10 busy in done cycle");
    chk(start_o, 1, "R10 start on done");
    chk(start_arg_sub_o, is_map, "R9 sub flag on fill");
    if (is_map) chk(start_arg_o, prm, "R9 fill arg");
    @(posedge clk_i); #1;
    fetch_done_i = 1'b0;
    chk(busy_o, 0, "R10 idle after done");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    repeat (3) @(posedge clk_i);
    #1;
    chk({busy_o, fetch_req_o, hit_o}, 3'b000, "R8 reset outputs");
    rst_ni = 1'b1;
    decay_cfg_i = 8'd20;
    // R8: address 0 after reset must miss
    dispatch(1'b1, '0, 16'h0011, 1'b0, "R8 first lookup misses");
    finish_fetch(0, 1'b1, 16'h0011);
    dispatch(1'b1, '0, 16'h0012, 1'b1, "R2 hit after fill");

    // R1: plain dispatches fetch and leave entry intact
    dispatch(1'b0, '0, 16'h0, 1'b0, "R1 plain same addr fetches");
    finish_fetch(1, 1'b0, 16'h0);
    dispatch(1'b0, 16'h0042, 16'h0, 1'b0, "R1 plain other addr fetches");
    finish_fetch(0, 1'b0, 16'h0);
    dispatch(1'b1, '0, 16'h0013, 1'b1, "R1 entry unchanged");
    dispatch(1'b1, 16'h0055, 16'h0014, 1'b0, "R2 tag mismatch misses");
    finish_fetch(2, 1'b1, 16'h0014);
    dispatch(1'b1, '0, 16'h0015, 1'b0, "R3 old tag replaced");
    finish_fetch(0, 1'b1, 16'h0015);

    // R4/R7/R6/R5 sweep: decay D, gap k, fetch latency
    a = 16'h0100;
    for (int d = 0; d <= 4; d++) begin
      for (int k = 1; k <= d + 3; k++) begin
        for (int lat = 0; lat <= 1; lat++) begin
          a = a + 1'b1;
          decay_cfg_i = CNT_W'(d);
          dispatch(1'b1, a, 16'h1000 + 16'(k), 1'b0, "R3 fresh address misses");
          finish_fetch(lat, 1'b1, 16'h1000 + 16'(k));
          decay_cfg_i = CNT_W'(d + 3);          // R6: later value must not matter
          repeat (k - 1) @(posedge clk_i);
          if (k == d + 1)
            dispatch(1'b1, a, 16'h2000, 1'b0, "R7 lookup in expiry cycle misses");
          else
            dispatch(1'b1, a, 16'h2000, k <= d, "R4 R6 decay window");
          if (k <= d) begin
            // reload with d+3 sampled at the hit (R5)
            repeat (d + 2) @(posedge clk_i);
            dispatch(1'b1, a, 16'h3000, 1'b1, "R5 reuse reloads lifetime");
            repeat (d + 3) @(posedge clk_i);
            dispatch(1'b1, a, 16'h3001, 1'b0, "R5 reloaded window ends");
            finish_fetch(0, 1'b1, 16'h3001);
          end else begin
            finish_fetch(lat, 1'b1, 16'h2000);
          end
        end
      end
    end
    done_flag = 1'b1;
    summary();
  end
endmodule